// File: doc/BRIEF.md
# Sixteen-Bit Capture/Reload/Baud Timer

This block is a 16-bit up-counter with one 16-bit reload/capture register and one control register. A byte-wide register port gives software access to all of them. The counter advances on an internal prescaled tick or on falling edges of an external count pin. An external trigger pin can do one of three things. In capture mode it snapshots the count into the reload register. In auto-reload mode it forces the reload value back into the counter. In baud mode it only raises a flag.

Baud mode is selected when either serial clock-source bit is set. In that mode the counter runs at oscillator/2 and reloads itself on every wrap. Each wrap produces one-cycle transmit and receive strobes for a serial port. The system clock `clk` is taken to be the oscillator. One machine cycle is `CYC_DIV` oscillator periods.

Top module: `t16_cap_timer`

## Requirements
- R1: While the run bit (control bit 0) is clear, the count, the reload register and both flags keep their values, whatever the pins do. Software writes still take effect.
- R2: With run set, counter-select clear and baud mode off, the count rises by one every 12 clocks. The internal prescaler restarts when run is clear, so the first increment lands on the 12th clock edge after the edge that sets run.
- R3: With counter-select (control bit 1) set, the count rises by one for each falling edge of `cnt_pin`. Each pin level must be held for at least 2 clocks, because the pin passes through a two-flop synchronizer.
- R4: If receive-clock (bit 4) or transmit-clock (bit 5) is set, baud behaviour applies and the capture select (bit 2) is ignored.
- R5: In capture mode (bit 2 set), a wrap from 0xFFFF sets the overflow flag (bit 7). A `trig_pin` falling edge with external-enable (bit 3) set copies the count into the reload register and sets the external flag (bit 6). With external-enable clear, the edge does nothing.
- R6: In auto-reload mode (bit 2 clear), a wrap from 0xFFFF sets the overflow flag and loads the count from the reload register.
- R7: In auto-reload mode, a `trig_pin` falling edge with external-enable set loads the count from the reload register and sets the external flag.
- R8: In baud mode with internal clocking, the count rises every 2 clocks. A wrap reloads the count without setting the overflow flag. In the following cycle it pulses `tx_tick` if bit 5 is set and `rx_tick` if bit 4 is set.
- R9: In baud mode, a `trig_pin` falling edge with external-enable set sets only the external flag. The count and the reload register do not change.
- R10: A falling edge acts exactly once. Holding the pin low causes no further action.
- R11: Both flags stay set until software writes 0 to them. A hardware set in the same cycle as a software clear leaves the flag set.
- R12: Register addresses are: 0 control, 1 count low, 2 count high, 3 reload low, 4 reload high. All registers reset to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| cnt_pin | input | 1 | External count input, falling edge counts |
| trig_pin | input | 1 | External trigger input, falling edge acts |
| tx_tick | output | 1 | One-cycle transmit strobe on baud wrap |
| rx_tick | output | 1 | One-cycle receive strobe on baud wrap |

## Verification
The bench goes after the cycle on which a pin edge takes effect. It clears a flag on exactly the clock where the counter wraps, so a design that let software win would read back a cleared overflow flag. A trigger pin is held low for many cycles to catch a design that re-triggers on a level, which would reload a freshly written count. Baud mode is run with capture-select also set and with an overflow wrap. These runs expose a design that captures on a baud trigger, sets the overflow flag in baud mode, or counts at the machine-cycle rate instead of oscillator/2. Prescaler phase is checked by stopping the timer on the exact clock of the last expected increment.

// File: rtl/t16_pkg.sv
`timescale 1ns/1ps
// Shared types for the 16-bit capture/reload/baud timer.
// Assumes a byte-wide register port and a 16-bit count split into two bytes.
package t16_pkg;
    localparam int TW = 16;
    localparam int DW = 8;
    localparam int AW = 3;

    typedef enum logic [AW-1:0] {
        A_CTRL   = 3'd0,
        A_CNT_LO = 3'd1,
        A_CNT_HI = 3'd2,
        A_RLD_LO = 3'd3,
        A_RLD_HI = 3'd4
    } t16_addr_e;

    // Packed MSB first: ovf is bit 7, run is bit 0.
    typedef struct packed {
        logic ovf;
        logic ext;
        logic tx_clk;
        logic rx_clk;
        logic ext_en;
        logic cap_sel;
        logic cnt_sel;
        logic run;
    } t16_ctrl_t;

    typedef enum logic [1:0] {
        M_RELOAD  = 2'd0,
        M_CAPTURE = 2'd1,
        M_BAUD    = 2'd2
    } t16_mode_e;
endpackage

// File: rtl/t16_pin_sync.sv
`timescale 1ns/1ps
// Two-flop synchronizer plus falling-edge detector for N asynchronous pins.
// The previous-value flop follows the synchronized level every cycle, so each
// edge produces a single-cycle pulse. Flops reset low, so a pin that is
// already low at reset gives no false edge.
module t16_pin_sync #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] pin,
    output logic [N-1:0] fall
);
    logic [N-1:0] meta_q;
    logic [N-1:0] sync_q;
    logic [N-1:0] prev_q;

    for (genvar i = 0; i < N; i++) begin : g_pin
        // Resynchronize one pin and keep its last synchronized level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q[i] <= 1'b0;
                sync_q[i] <= 1'b0;
                prev_q[i] <= 1'b0;
            end else begin
                meta_q[i] <= pin[i];
                sync_q[i] <= meta_q[i];
                prev_q[i] <= sync_q[i];
            end
        end
        assign fall[i] = prev_q[i] & ~sync_q[i];
    end
endmodule

// File: rtl/t16_div.sv
`timescale 1ns/1ps
// Tick divider: strobes once every DIV clocks while run is high.
// Holds at zero while run is low, so the phase is fixed by the run edge.
module t16_div #(
    parameter int DIV = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic stb
);
    localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [W-1:0] LAST = W'(DIV - 1);

    logic [W-1:0] cnt_q;

    // Count modulo DIV, restarting whenever run is dropped.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)   cnt_q <= '0;
        else if (cnt_q == LAST) cnt_q <= '0;
        else                  cnt_q <= cnt_q + 1'b1;
    end

    assign stb = run && (cnt_q == LAST);
endmodule

// File: rtl/t16_core.sv
`timescale 1ns/1ps
// Counter, reload/capture register and control register with mode logic.
// Assumes the edge inputs are single-cycle pulses that are already synchronized.
// Software writes to the data registers win over hardware updates, except that
// a capture wins over a write to the reload register. Hardware flag sets win
// over software clears.
module t16_core
    import t16_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic            cyc_stb,
    input  logic            baud_stb,
    input  logic            cnt_fall,
    input  logic            trig_fall,
    output t16_ctrl_t       ctrl_q,
    output logic [TW-1:0]   cnt_q,
    output logic [TW-1:0]   rld_q,
    output logic            tx_tick,
    output logic            rx_tick
);
    t16_mode_e      mode;
    logic           inc, trig, carry, wrap_tick, cap_evt;
    logic           ovf_set, ext_set;
    logic [TW-1:0]  cnt_adv, cnt_hw, rld_hw, cnt_d, rld_d;
    t16_ctrl_t      ctrl_d;

    // Decode mode and the count event for this cycle.
    always_comb begin
        if (ctrl_q.rx_clk || ctrl_q.tx_clk) mode = M_BAUD;
        else if (ctrl_q.cap_sel)            mode = M_CAPTURE;
        else                                mode = M_RELOAD;
        if (ctrl_q.cnt_sel)      inc = ctrl_q.run & cnt_fall;
        else if (mode == M_BAUD) inc = ctrl_q.run & baud_stb;
        else                     inc = ctrl_q.run & cyc_stb;
        trig    = ctrl_q.run & ctrl_q.ext_en & trig_fall;
        carry   = inc & (&cnt_q);
        cnt_adv = cnt_q + TW'(inc);
    end

    // Hardware next state for count, reload register and flags, by mode.
    always_comb begin
        cnt_hw    = cnt_adv;
        rld_hw    = rld_q;
        ovf_set   = 1'b0;
        ext_set   = 1'b0;
        wrap_tick = 1'b0;
        cap_evt   = 1'b0;
        unique case (mode)
            M_BAUD: begin
                ext_set = trig;
                if (carry) begin
                    cnt_hw    = rld_q;
                    wrap_tick = 1'b1;
                end
            end
            M_CAPTURE: begin
                ovf_set = carry;
                if (trig) begin
                    rld_hw  = cnt_adv;
                    ext_set = 1'b1;
                    cap_evt = 1'b1;
                end
            end
            default: begin
                ovf_set = carry;
                ext_set = trig;
                if (carry || trig) cnt_hw = rld_q;
            end
        endcase
    end

    // Merge software writes with the hardware updates.
    always_comb begin
        cnt_d  = cnt_hw;
        rld_d  = rld_hw;
        ctrl_d = ctrl_q;
        if (wr_en) begin
            unique case (addr)
                A_CTRL:   ctrl_d = t16_ctrl_t'(wdata);
                A_CNT_LO: cnt_d[DW-1:0]  = wdata;
                A_CNT_HI: cnt_d[TW-1:DW] = wdata;
                A_RLD_LO: if (!cap_evt) rld_d[DW-1:0]  = wdata;
                A_RLD_HI: if (!cap_evt) rld_d[TW-1:DW] = wdata;
                default: ;
            endcase
        end
        ctrl_d.ovf = ctrl_d.ovf | ovf_set;
        ctrl_d.ext = ctrl_d.ext | ext_set;
    end

    // State registers and the registered serial strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cnt_q   <= '0;
            rld_q   <= '0;
            tx_tick <= 1'b0;
            rx_tick <= 1'b0;
        end else begin
            ctrl_q  <= ctrl_d;
            cnt_q   <= cnt_d;
            rld_q   <= rld_d;
            tx_tick <= wrap_tick & ctrl_q.tx_clk;
            rx_tick <= wrap_tick & ctrl_q.rx_clk;
        end
    end
endmodule

// File: rtl/t16_cap_timer.sv
`timescale 1ns/1ps
// Top of the 16-bit capture/reload/baud timer.
// Ties together the pin synchronizers, the two tick dividers (machine cycle and
// baud rate) and the core, and muxes the register read port.
// Assumes clk is the oscillator and both pins are asynchronous.
module t16_cap_timer
    import t16_pkg::*;
#(
    parameter int CYC_DIV  = 12,
    parameter int BAUD_DIV = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [2:0]    addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata,
    input  logic          cnt_pin,
    input  logic          trig_pin,
    output logic          tx_tick,
    output logic          rx_tick
);
    localparam int NPIN = 2;

    logic [NPIN-1:0] pin_fall;
    logic            cyc_stb, baud_stb;
    t16_ctrl_t       ctrl_q;
    logic [TW-1:0]   cnt_q, rld_q;

    t16_pin_sync #(.N(NPIN)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   ({trig_pin, cnt_pin}),
        .fall  (pin_fall)
    );

    t16_div #(.DIV(CYC_DIV)) u_cyc_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .stb   (cyc_stb)
    );

    t16_div #(.DIV(BAUD_DIV)) u_baud_div (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (ctrl_q.run),
        .stb   (baud_stb)
    );

    t16_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wdata     (wdata),
        .cyc_stb   (cyc_stb),
        .baud_stb  (baud_stb),
        .cnt_fall  (pin_fall[0]),
        .trig_fall (pin_fall[1]),
        .ctrl_q    (ctrl_q),
        .cnt_q     (cnt_q),
        .rld_q     (rld_q),
        .tx_tick   (tx_tick),
        .rx_tick   (rx_tick)
    );

    // Register read multiplexer.
    always_comb begin
        unique case (addr)
            A_CTRL:   rdata = ctrl_q;
            A_CNT_LO: rdata = cnt_q[DW-1:0];
            A_CNT_HI: rdata = cnt_q[TW-1:DW];
            A_RLD_LO: rdata = rld_q[DW-1:0];
            A_RLD_HI: rdata = rld_q[TW-1:DW];
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/t16_cap_timer_chk.sv
`timescale 1ns/1ps
// Property checker for t16_cap_timer, attached with bind.
// Watches the control, count and reload state across cycles.
module t16_cap_timer_chk
    import t16_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input t16_ctrl_t     ctrl,
    input logic [TW-1:0] cnt,
    input logic [TW-1:0] rld,
    input logic          tx_tick,
    input logic          rx_tick
);
    logic baud;
    assign baud = ctrl.rx_clk | ctrl.tx_clk;

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !wr_en) |=> ($stable(cnt) && $stable(rld) && $stable(ctrl))); // R1

    AST_BAUD_NO_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (baud && !ctrl.ovf && !wr_en) |=> !ctrl.ovf); // R8

    AST_TICK_AFTER_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        ((tx_tick || rx_tick) && !$past(wr_en)) |-> (cnt == rld)); // R8

    AST_TX_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tick |-> $past(ctrl.tx_clk)); // R8

    AST_RX_NEEDS_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        rx_tick |-> $past(ctrl.rx_clk)); // R8

    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.ovf && !wr_en) |=> ctrl.ovf); // R11

    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.ext && !wr_en) |=> ctrl.ext); // R11

    AST_BAUD_RLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (baud && !wr_en) |=> $stable(rld)); // R9

    AST_CAPTURE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!baud && ctrl.cap_sel && ctrl.run && !wr_en && !ctrl.ext) |=> ($stable(rld) || ctrl.ext)); // R5
endmodule

bind t16_cap_timer t16_cap_timer_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .ctrl    (ctrl_q),
    .cnt     (cnt_q),
    .rld     (rld_q),
    .tx_tick (tx_tick),
    .rx_tick (rx_tick)
);

// File: tb/t16_cap_timer_tb.sv
`timescale 1ns/1ps
// Scoreboard bench: rd_chk pushes the expected byte, the monitor pops and compares.
module t16_cap_timer_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       cnt_pin = 1'b1;
    logic       trig_pin = 1'b1;
    logic       tx_tick, rx_tick;
    logic       rd_vld = 1'b0;

    int checks = 0;
    int errors = 0;
    int tx_seen = 0;
    int rx_seen = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } exp_t;
    exp_t sb[$];

    localparam logic [2:0] RC = 3'd0, CL = 3'd1, CH = 3'd2, RL = 3'd3, RH = 3'd4;

    always #4 clk = ~clk;

    t16_cap_timer u_dut (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .addr (addr),
        .wdata (wdata), .rdata (rdata), .cnt_pin (cnt_pin),
        .trig_pin (trig_pin), .tx_tick (tx_tick), .rx_tick (rx_tick)
    );

    // Monitor: sample between edges, pop the expected value and compare.
    always @(posedge clk) begin
        #2;
        if (tx_tick) tx_seen++;
        if (rx_tick) rx_seen++;
        if (rd_vld && sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            checks++;
            if (rdata !== e.exp) begin
                errors++;
                $display("FAIL %s act=%h exp=%h", e.tag, rdata, e.exp);
            end
        end
    end

    // All tasks are entered at a negative edge and return at one.
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string tag);
        exp_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        addr = a; rd_vld = 1'b1;
        @(negedge clk);
        rd_vld = 1'b0;
    endtask

    task automatic val_chk(input int act, input int e, input string tag);
        checks++;
        if (act != e) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, e);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set16(input logic [2:0] lo, input logic [15:0] v);
        wr(lo, v[7:0]);
        wr(lo + 3'd1, v[15:8]);
    endtask

    task automatic pulse_cnt(input int n);
        for (int i = 0; i < n; i++) begin
            cnt_pin = 1'b0; idle(4);
            cnt_pin = 1'b1; idle(4);
        end
    endtask

    task automatic pulse_trig();
        trig_pin = 1'b0; idle(4);
        trig_pin = 1'b1; idle(4);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int t0, r0;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R12: reset values and address map
        rd_chk(RC, 8'h00, "R12 ctrl reset");
        rd_chk(CL, 8'h00, "R12 count reset");
        rd_chk(RH, 8'h00, "R12 reload reset");

        // R2: internal ticks, 5 machine cycles
        set16(CL, 16'h0000);
        wr(RC, 8'h01);
        idle(12 * 5 - 1);
        wr(RC, 8'h00);
        rd_chk(CL, 8'h05, "R2 machine-cycle count");

        // R1: stopped timer ignores pins and time
        wr(RC, 8'h0A);
        pulse_cnt(3);
        pulse_trig();
        idle(30);
        rd_chk(CL, 8'h05, "R1 count held");
        rd_chk(RC, 8'h0A, "R1 no flags");
        rd_chk(RL, 8'h00, "R1 no capture");

        // R3: external counting
        set16(CL, 16'h0100);
        wr(RC, 8'h03);
        pulse_cnt(7);
        idle(4);
        wr(RC, 8'h02);
        rd_chk(CL, 8'h07, "R3 edge count low");
        rd_chk(CH, 8'h01, "R3 edge count high");

        // R5: capture on trigger
        set16(CL, 16'hBEEF);
        set16(RL, 16'h0000);
        wr(RC, 8'h0F);
        pulse_trig();
        rd_chk(RL, 8'hEF, "R5 capture low");
        rd_chk(RH, 8'hBE, "R5 capture high");
        rd_chk(RC, 8'h4F, "R5 ext flag");
        // R5: external enable clear -> trigger ignored
        wr(RC, 8'h07);
        set16(CL, 16'h1111);
        pulse_trig();
        rd_chk(RL, 8'hEF, "R5 no capture without enable");
        rd_chk(RC, 8'h07, "R5 no flag without enable");
        // R5: wrap in capture mode
        set16(CL, 16'hFFFF);
        pulse_cnt(1);
        rd_chk(CL, 8'h00, "R5 wrap count");
        rd_chk(RC, 8'h87, "R5 ovf flag");
        rd_chk(RH, 8'hBE, "R5 reload untouched on wrap");

        // R11: software clear, then clear in the same cycle as a set
        wr(RC, 8'h07);
        rd_chk(RC, 8'h07, "R11 flag cleared");
        set16(CL, 16'hFFFF);
        cnt_pin = 1'b0;
        idle(2);
        wr(RC, 8'h07);
        rd_chk(RC, 8'h87, "R11 hardware set wins");
        cnt_pin = 1'b1;
        idle(4);

        // R6: auto-reload on wrap
        wr(RC, 8'h00);
        set16(RL, 16'h4000);
        set16(CL, 16'hFFFE);
        wr(RC, 8'h03);
        pulse_cnt(2);
        rd_chk(CH, 8'h40, "R6 reload high");
        rd_chk(CL, 8'h00, "R6 reload low");
        rd_chk(RC, 8'h83, "R6 ovf flag");

        // R7: trigger reload
        wr(RC, 8'h0B);
        set16(CL, 16'h0123);
        pulse_trig();
        rd_chk(CH, 8'h40, "R7 trigger reload");
        rd_chk(RC, 8'h4B, "R7 ext flag");

        // R10: held-low trigger acts once
        wr(RC, 8'h0B);
        trig_pin = 1'b0;
        idle(6);
        set16(CL, 16'h0055);
        idle(20);
        rd_chk(CL, 8'h55, "R10 no repeat reload");
        rd_chk(RC, 8'h4B, "R10 single flag set");
        trig_pin = 1'b1;
        idle(4);

        // R9 and R4: baud mode, trigger only flags even with capture select
        wr(RC, 8'h00);
        set16(CL, 16'h2222);
        set16(RL, 16'h3333);
        wr(RC, 8'h2F);
        pulse_trig();
        rd_chk(RC, 8'h6F, "R9 ext flag in baud");
        rd_chk(RL, 8'h33, "R4 no capture in baud");
        rd_chk(CL, 8'h22, "R9 count untouched");

        // R8: internal baud clocking at clk/2, tx only
        wr(RC, 8'h00);
        set16(CL, 16'hFFF0);
        set16(RL, 16'hFFF0);
        t0 = tx_seen; r0 = rx_seen;
        wr(RC, 8'h21);
        idle(2 * 40 - 1);
        wr(RC, 8'h20);
        idle(2);
        rd_chk(CL, 8'hF8, "R8 baud rate count");
        rd_chk(RC, 8'h20, "R8 no ovf in baud");
        val_chk(tx_seen - t0, 2, "R8 tx ticks");
        val_chk(rx_seen - r0, 0, "R8 rx ticks off");

        // R8: both strobes
        set16(CL, 16'hFFFF);
        set16(RL, 16'hFFFE);
        t0 = tx_seen; r0 = rx_seen;
        wr(RC, 8'h31);
        idle(2 * 3 - 1);
        wr(RC, 8'h30);
        idle(2);
        rd_chk(CL, 8'hFE, "R8 reload value");
        val_chk(tx_seen - t0, 2, "R8 tx both");
        val_chk(rx_seen - r0, 2, "R8 rx both");

        idle(4);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule